// File: doc/BRIEF.md
# Snooped Miss Conflict Table

This block sits in each cache controller on a split-transaction snooping bus. It keeps a copy of every request that is still in flight on the bus. Every controller sees the same address phases, so all copies stay the same. Every non-NOP request on the address bus is recorded, including the controller's own. An entry leaves the table when the data-phase response carrying its tag completes.

A new local miss is parked in a single holding register and compared with all live entries before the controller asks for the address bus. There are four outcomes:

- **Join:** a read that finds a pending read to the same line is not issued. It marks that entry so this controller takes the response and asserts the shared line.
- **Wait:** a request that collides with an exclusive request, or an exclusive request that collides with anything, waits until the colliding entry retires.
- **NOP slot:** if a colliding request appears while the controller is waiting for the bus, the slot it is granted carries a NOP and the request stays held. The same happens if the table fills in that time.
- **Upgrade conversion:** a held upgrade whose line is claimed exclusively by another controller is later issued as a read-exclusive.

Top module: `miss_conflict_table`

## Requirements

Command encoding on all 2-bit command ports: 0 = NOP, 1 = read (RD), 2 = read-exclusive (RDX), 3 = upgrade (UPG). The local requester ID is parameter MY_ID (default 0).

- R1: While reset is held and on the first cycle after it, loc_ready is 1 and bus_req, slot_valid, shr_out, rsp_take and tbl_full are 0.
- R2: Every snooped request with a non-NOP command takes one free entry, whatever its source. A snooped NOP takes none. tbl_full is 1 exactly when all ENTRIES entries are live.
- R3: A response whose tag matches a live entry frees that entry from the next cycle on. rsp_take is 1 in the response cycle exactly when that entry was snooped from MY_ID or was joined by a local read.
- R4: A local RD whose line matches a live RD entry is never put on the bus. shr_out pulses for one cycle, in the cycle after acceptance, and loc_ready returns the cycle after that.
- R5: A local request is held (bus_req 0, loc_ready 0) if its line matches a live RDX or UPG entry, or if it is itself RDX/UPG and its line matches any live entry. This lasts until that entry's response completes.
- R6: The lookup runs in the cycle after acceptance, and in the cycle after the blocking entry retires. If it finds no conflict and the table is not full, bus_req is 1 from the following cycle until a grant.
- R7: A grant with no conflict drives slot_valid=1, slot_cmd = the held command and slot_addr = the held line in the grant cycle. loc_ready is 1 in the next cycle.
- R8: If a request from another source to the held line is snooped while bus_req is 1, the granted slot carries NOP. The request stays held (loc_ready 0) and is looked up again.
- R9: A held UPG whose line is claimed by another source's RDX or UPG is issued as RDX.
- R10: While tbl_full is 1, no held request starts arbitrating. A grant that arrives while the table is full carries NOP.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| loc_valid | input | 1 | Local miss offered |
| loc_cmd | input | 2 | Local miss command |
| loc_addr | input | ADDR_W | Local miss line address |
| loc_ready | output | 1 | Holding register free; offer accepted this cycle |
| snp_valid | input | 1 | Address-phase request seen on the bus |
| snp_cmd | input | 2 | Snooped command |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_src | input | ID_W | Requester ID of the snooped request |
| snp_tag | input | TAG_W | Bus tag of the snooped request |
| rsp_valid | input | 1 | Data-phase response completes |
| rsp_tag | input | TAG_W | Tag of the completing response |
| rsp_take | output | 1 | This controller captures the completing response |
| bus_gnt | input | 1 | Address-bus slot granted this cycle |
| bus_req | output | 1 | Request for the address bus |
| slot_valid | output | 1 | Slot is being driven this cycle |
| slot_cmd | output | 2 | Command driven in the slot (NOP on conflict) |
| slot_addr | output | ADDR_W | Line address driven in the slot |
| shr_out | output | 1 | Shared-line assertion for a joined read |
| tbl_full | output | 1 | All entries live |

## Verification

Each internal fault shows up at the ports, and how soon depends on the fault:

- **Stale live bit:** shows as tbl_full that never falls, or as a held request whose bus_req never comes back one cycle after the lookup that follows the blocking response.
- **Lost or spurious local mark:** appears only later, as a wrong rsp_take in the cycle that entry's response completes.
- **Sequencer off by one state:** moves the rise of bus_req away from the second cycle after acceptance. It can also turn a granted slot into a real command when NOP is due.

The stimulus is placed so that each of these shows at a fixed cycle.

// File: rtl/mct_pkg.sv
// Shared types for the snooped miss conflict table.
// Assumes a 2-bit bus command encoding fixed across the bus.
package mct_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_RD  = 2'd1,
        CMD_RDX = 2'd2,
        CMD_UPG = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_LOOK = 2'd1,
        HS_WAIT = 2'd2,
        HS_ARB  = 2'd3
    } hold_st_e;

    // True for commands that claim exclusive ownership of a line.
    function automatic logic is_excl(input bus_cmd_e c);
        return (c == CMD_RDX) || (c == CMD_UPG);
    endfunction

endpackage

// File: rtl/mct_first_set.sv
// Lowest-index set bit finder.
// Assumes N >= 1; idx is 0 when nothing is set.
module mct_first_set #(
    parameter  int N  = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);

    // Scan from the top so the lowest set index wins.
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/mct_entry_store.sv
// Fully associative store of in-flight bus requests.
// Allocates on every snooped non-NOP command and frees on the matching
// response tag. It also gives a line-address hit vector for the held miss.
// Assumes bus tags of live entries are unique and that no request is
// snooped while the table is full (the issue logic ensures this locally).
module mct_entry_store
    import mct_pkg::*;
#(
    parameter  int             ENTRIES = 8,
    parameter  int             ADDR_W  = 26,
    parameter  int             ID_W    = 2,
    parameter  int             TAG_W   = 3,
    parameter  logic [ID_W-1:0] MY_ID  = '0,
    localparam int             IW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [ID_W-1:0]   snp_src,
    input  logic [TAG_W-1:0]  snp_tag,
    input  logic              rsp_valid,
    input  logic [TAG_W-1:0]  rsp_tag,
    input  logic [ADDR_W-1:0] look_addr,
    input  logic              join_en,
    input  logic [IW-1:0]     join_idx,
    output logic [ENTRIES-1:0] hit_vec,
    output logic [1:0]        ent_cmd [ENTRIES],
    output logic [ID_W-1:0]   ent_src [ENTRIES],
    output logic [TAG_W-1:0]  ent_tag [ENTRIES],
    output logic              full,
    output logic              take
);

    logic [ENTRIES-1:0] valid_vec;
    logic [ENTRIES-1:0] local_vec;
    logic [ENTRIES-1:0] retire_vec;
    logic               free_found;
    logic [IW-1:0]      free_idx;
    logic               alloc_en;

    // Pick the lowest free slot for the next snooped request.
    mct_first_set #(.N(ENTRIES)) u_free (
        .vec   (~valid_vec),
        .found (free_found),
        .idx   (free_idx)
    );

    assign alloc_en = snp_valid && (bus_cmd_e'(snp_cmd) != CMD_NOP) && free_found;
    assign full     = &valid_vec;
    assign take     = |(retire_vec & local_vec);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic              v_q;
        logic              l_q;
        logic [ADDR_W-1:0] a_q;
        logic [1:0]        c_q;
        logic [ID_W-1:0]   s_q;
        logic [TAG_W-1:0]  t_q;
        logic              wr_here;

        assign wr_here       = alloc_en && (free_idx == IW'(g));
        assign retire_vec[g] = rsp_valid && v_q && (t_q == rsp_tag);
        assign hit_vec[g]    = v_q && !retire_vec[g] && (a_q == look_addr);
        assign valid_vec[g]  = v_q;
        assign local_vec[g]  = l_q;
        assign ent_cmd[g]    = c_q;
        assign ent_src[g]    = s_q;
        assign ent_tag[g]    = t_q;

        // Entry live bit and local-capture mark.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                l_q <= 1'b0;
            end else if (wr_here) begin
                v_q <= 1'b1;
                l_q <= (snp_src == MY_ID);
            end else if (retire_vec[g]) begin
                v_q <= 1'b0;
                l_q <= 1'b0;
            end else if (join_en && (join_idx == IW'(g))) begin
                l_q <= 1'b1;
            end
        end

        // Entry payload, written only on allocation.
        always_ff @(posedge clk) begin
            if (wr_here) begin
                a_q <= snp_addr;
                c_q <= snp_cmd;
                s_q <= snp_src;
                t_q <= snp_tag;
            end
        end
    end

endmodule

// File: rtl/mct_hold_ctrl.sv
// Sequencer for the single held local miss: lookup, join, wait,
// arbitrate and slot fill. Assumes the hit inputs describe the lowest
// matching live entry for the held line in the current cycle.
module mct_hold_ctrl
    import mct_pkg::*;
#(
    parameter  int              ENTRIES = 8,
    parameter  int              ADDR_W  = 26,
    parameter  int              ID_W    = 2,
    parameter  int              TAG_W   = 3,
    parameter  logic [ID_W-1:0] MY_ID   = '0,
    localparam int              IW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loc_valid,
    input  logic [1:0]        loc_cmd,
    input  logic [ADDR_W-1:0] loc_addr,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [ID_W-1:0]   snp_src,
    input  logic              rsp_valid,
    input  logic [TAG_W-1:0]  rsp_tag,
    input  logic              bus_gnt,
    input  logic              hit_any,
    input  logic [IW-1:0]     hit_idx,
    input  logic [1:0]        hit_cmd,
    input  logic [ID_W-1:0]   hit_src,
    input  logic [TAG_W-1:0]  hit_tag,
    input  logic              full,
    output logic [ADDR_W-1:0] held_addr,
    output logic              join_en,
    output logic [IW-1:0]     join_idx,
    output logic              loc_ready,
    output logic              bus_req,
    output logic              slot_valid,
    output logic [1:0]        slot_cmd,
    output logic              shr_out
);

    hold_st_e          st_q, st_d;
    bus_cmd_e          cmd_q, cmd_d;
    logic [ADDR_W-1:0] addr_q;
    logic [TAG_W-1:0]  blk_q, blk_d;
    logic              conf_q, conf_d;
    logic              snp_conf;
    logic              snp_excl;
    bus_cmd_e          hcmd;

    assign hcmd      = bus_cmd_e'(hit_cmd);
    assign snp_conf  = snp_valid && (bus_cmd_e'(snp_cmd) != CMD_NOP)
                       && (snp_addr == addr_q) && (snp_src != MY_ID);
    assign snp_excl  = snp_conf && is_excl(bus_cmd_e'(snp_cmd));
    assign held_addr = addr_q;
    assign join_idx  = hit_idx;

    // Next-state and output decode for the held miss.
    always_comb begin
        st_d       = st_q;
        cmd_d      = cmd_q;
        blk_d      = blk_q;
        conf_d     = conf_q;
        join_en    = 1'b0;
        shr_out    = 1'b0;
        loc_ready  = 1'b0;
        bus_req    = 1'b0;
        slot_valid = 1'b0;
        slot_cmd   = CMD_NOP;
        unique case (st_q)
            HS_IDLE: begin
                loc_ready = 1'b1;
                if (loc_valid && (bus_cmd_e'(loc_cmd) != CMD_NOP)) begin
                    st_d  = HS_LOOK;
                    cmd_d = bus_cmd_e'(loc_cmd);
                end
            end
            HS_LOOK: begin
                if (snp_conf) begin
                    st_d = HS_LOOK;
                    if (snp_excl && (cmd_q == CMD_UPG)) cmd_d = CMD_RDX;
                end else if (hit_any) begin
                    if ((cmd_q == CMD_RD) && (hcmd == CMD_RD)) begin
                        join_en = 1'b1;
                        shr_out = 1'b1;
                        st_d    = HS_IDLE;
                    end else begin
                        blk_d = hit_tag;
                        st_d  = HS_WAIT;
                        if ((cmd_q == CMD_UPG) && is_excl(hcmd) && (hit_src != MY_ID))
                            cmd_d = CMD_RDX;
                    end
                end else if (!full) begin
                    st_d   = HS_ARB;
                    conf_d = 1'b0;
                end
            end
            HS_WAIT: begin
                if (snp_excl && (cmd_q == CMD_UPG)) cmd_d = CMD_RDX;
                if (rsp_valid && (rsp_tag == blk_q)) st_d = HS_LOOK;
            end
            HS_ARB: begin
                bus_req = 1'b1;
                if (snp_conf) conf_d = 1'b1;
                if (snp_excl && (cmd_q == CMD_UPG)) cmd_d = CMD_RDX;
                if (bus_gnt) begin
                    slot_valid = 1'b1;
                    if (conf_q || snp_conf || full) begin
                        slot_cmd = CMD_NOP;
                        st_d     = HS_LOOK;
                        conf_d   = 1'b0;
                    end else begin
                        slot_cmd = cmd_q;
                        st_d     = HS_IDLE;
                    end
                end
            end
            default: st_d = HS_IDLE;
        endcase
    end

    // State, command, blocking tag and conflict flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= HS_IDLE;
            cmd_q  <= CMD_NOP;
            blk_q  <= '0;
            conf_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            cmd_q  <= cmd_d;
            blk_q  <= blk_d;
            conf_q <= conf_d;
        end
    end

    // Capture the line address of an accepted local miss.
    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else if ((st_q == HS_IDLE) && loc_valid) addr_q <= loc_addr;
    end

endmodule

// File: rtl/miss_conflict_table.sv
// Top of the snooped miss conflict table: entry store, hit selection and
// held-miss sequencer. Assumes a single outstanding held local miss and
// that all controllers on the bus snoop the same address phases.
module miss_conflict_table
    import mct_pkg::*;
#(
    parameter int              ENTRIES = 8,
    parameter int              ADDR_W  = 26,
    parameter int              ID_W    = 2,
    parameter int              TAG_W   = 3,
    parameter logic [ID_W-1:0] MY_ID   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loc_valid,
    input  logic [1:0]        loc_cmd,
    input  logic [ADDR_W-1:0] loc_addr,
    output logic              loc_ready,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [ID_W-1:0]   snp_src,
    input  logic [TAG_W-1:0]  snp_tag,
    input  logic              rsp_valid,
    input  logic [TAG_W-1:0]  rsp_tag,
    output logic              rsp_take,
    input  logic              bus_gnt,
    output logic              bus_req,
    output logic              slot_valid,
    output logic [1:0]        slot_cmd,
    output logic [ADDR_W-1:0] slot_addr,
    output logic              shr_out,
    output logic              tbl_full
);

    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] hit_vec;
    logic [1:0]         ent_cmd [ENTRIES];
    logic [ID_W-1:0]    ent_src [ENTRIES];
    logic [TAG_W-1:0]   ent_tag [ENTRIES];
    logic               hit_any;
    logic [IW-1:0]      hit_idx;
    logic [ADDR_W-1:0]  held_addr;
    logic               join_en;
    logic [IW-1:0]      join_idx;

    mct_entry_store #(
        .ENTRIES (ENTRIES), .ADDR_W (ADDR_W), .ID_W (ID_W),
        .TAG_W (TAG_W), .MY_ID (MY_ID)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .snp_valid (snp_valid),
        .snp_cmd   (snp_cmd),
        .snp_addr  (snp_addr),
        .snp_src   (snp_src),
        .snp_tag   (snp_tag),
        .rsp_valid (rsp_valid),
        .rsp_tag   (rsp_tag),
        .look_addr (held_addr),
        .join_en   (join_en),
        .join_idx  (join_idx),
        .hit_vec   (hit_vec),
        .ent_cmd   (ent_cmd),
        .ent_src   (ent_src),
        .ent_tag   (ent_tag),
        .full      (tbl_full),
        .take      (rsp_take)
    );

    // Lowest matching entry stands for the conflict.
    mct_first_set #(.N(ENTRIES)) u_hit (
        .vec   (hit_vec),
        .found (hit_any),
        .idx   (hit_idx)
    );

    mct_hold_ctrl #(
        .ENTRIES (ENTRIES), .ADDR_W (ADDR_W), .ID_W (ID_W),
        .TAG_W (TAG_W), .MY_ID (MY_ID)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .loc_valid  (loc_valid),
        .loc_cmd    (loc_cmd),
        .loc_addr   (loc_addr),
        .snp_valid  (snp_valid),
        .snp_cmd    (snp_cmd),
        .snp_addr   (snp_addr),
        .snp_src    (snp_src),
        .rsp_valid  (rsp_valid),
        .rsp_tag    (rsp_tag),
        .bus_gnt    (bus_gnt),
        .hit_any    (hit_any),
        .hit_idx    (hit_idx),
        .hit_cmd    (ent_cmd[hit_idx]),
        .hit_src    (ent_src[hit_idx]),
        .hit_tag    (ent_tag[hit_idx]),
        .full       (tbl_full),
        .held_addr  (held_addr),
        .join_en    (join_en),
        .join_idx   (join_idx),
        .loc_ready  (loc_ready),
        .bus_req    (bus_req),
        .slot_valid (slot_valid),
        .slot_cmd   (slot_cmd),
        .shr_out    (shr_out)
    );

    assign slot_addr = held_addr;

endmodule

// File: rtl/mct_checker.sv
// Port-level properties of the miss conflict table, bound to its top.
module mct_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_gnt,
    input logic       rsp_valid,
    input logic       snp_valid,
    input logic [1:0] snp_cmd,
    input logic       loc_ready,
    input logic       bus_req,
    input logic       slot_valid,
    input logic [1:0] slot_cmd,
    input logic       shr_out,
    input logic       rsp_take,
    input logic       tbl_full
);

    // R1: first cycle out of reset is idle and empty
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (loc_ready && !bus_req && !tbl_full));

    // R2: no request may be snooped into a full table
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        !(snp_valid && (snp_cmd != 2'd0) && tbl_full));

    // R3: capture only happens on a completing response
    a_r3_take_on_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_take |-> rsp_valid);

    // R4: a joined read never reaches the bus
    a_r4_join_silent: assert property (@(posedge clk) disable iff (!rst_n)
        shr_out |-> (!bus_req && !slot_valid));

    // R6: arbitration persists until a grant
    a_r6_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> bus_req);

    // R7: a real command in the slot frees the holding register
    a_r7_ready_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && (slot_cmd != 2'd0)) |=> loc_ready);

    // R8: a slot is only driven in a granted cycle
    a_r8_slot_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid |-> (bus_gnt && bus_req));

    // R10: a grant into a full table carries NOP
    a_r10_full_nop: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && tbl_full) |-> (slot_cmd == 2'd0));

endmodule

bind miss_conflict_table mct_checker u_mct_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_gnt    (bus_gnt),
    .rsp_valid  (rsp_valid),
    .snp_valid  (snp_valid),
    .snp_cmd    (snp_cmd),
    .loc_ready  (loc_ready),
    .bus_req    (bus_req),
    .slot_valid (slot_valid),
    .slot_cmd   (slot_cmd),
    .shr_out    (shr_out),
    .rsp_take   (rsp_take),
    .tbl_full   (tbl_full)
);

// File: tb/miss_conflict_table_bench.sv
// Self-checking bench: table-driven fill/retire walk, then directed cases.
module miss_conflict_table_bench;

    localparam int CLK_P  = 10;
    localparam int ADDR_W = 26;
    localparam int ID_W   = 2;
    localparam int TAG_W  = 3;
    localparam int NVEC   = 13;

    typedef struct packed {
        logic        rsp;     // 0 = snoop, 1 = response
        logic [1:0]  cmd;
        logic [11:0] addr;
        logic [1:0]  src;
        logic [2:0]  tag;
        logic        e_take;
        logic        e_full;
    } vec_t;

    // Fill with 8 real requests (one NOP ignored), then retire and refill.
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 2'd1, 12'h100, 2'd1, 3'd0, 1'b0, 1'b0},
        '{1'b0, 2'd2, 12'h101, 2'd2, 3'd1, 1'b0, 1'b0},
        '{1'b0, 2'd1, 12'h102, 2'd0, 3'd2, 1'b0, 1'b0},
        '{1'b0, 2'd0, 12'h103, 2'd1, 3'd7, 1'b0, 1'b0},
        '{1'b0, 2'd3, 12'h104, 2'd1, 3'd3, 1'b0, 1'b0},
        '{1'b0, 2'd1, 12'h105, 2'd3, 3'd4, 1'b0, 1'b0},
        '{1'b0, 2'd1, 12'h106, 2'd1, 3'd5, 1'b0, 1'b0},
        '{1'b0, 2'd1, 12'h107, 2'd2, 3'd6, 1'b0, 1'b0},
        '{1'b0, 2'd2, 12'h108, 2'd1, 3'd7, 1'b0, 1'b1},
        '{1'b1, 2'd0, 12'h000, 2'd0, 3'd2, 1'b1, 1'b0},
        '{1'b0, 2'd1, 12'h109, 2'd0, 3'd2, 1'b0, 1'b1},
        '{1'b1, 2'd0, 12'h000, 2'd0, 3'd0, 1'b0, 1'b0},
        '{1'b1, 2'd0, 12'h000, 2'd0, 3'd2, 1'b1, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              loc_valid;
    logic [1:0]        loc_cmd;
    logic [ADDR_W-1:0] loc_addr;
    logic              loc_ready;
    logic              snp_valid;
    logic [1:0]        snp_cmd;
    logic [ADDR_W-1:0] snp_addr;
    logic [ID_W-1:0]   snp_src;
    logic [TAG_W-1:0]  snp_tag;
    logic              rsp_valid;
    logic [TAG_W-1:0]  rsp_tag;
    logic              rsp_take;
    logic              bus_gnt;
    logic              bus_req;
    logic              slot_valid;
    logic [1:0]        slot_cmd;
    logic [ADDR_W-1:0] slot_addr;
    logic              shr_out;
    logic              tbl_full;

    int n_cmp = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    miss_conflict_table u_miss_conflict_table (
        .clk (clk), .rst_n (rst_n),
        .loc_valid (loc_valid), .loc_cmd (loc_cmd), .loc_addr (loc_addr),
        .loc_ready (loc_ready),
        .snp_valid (snp_valid), .snp_cmd (snp_cmd), .snp_addr (snp_addr),
        .snp_src (snp_src), .snp_tag (snp_tag),
        .rsp_valid (rsp_valid), .rsp_tag (rsp_tag), .rsp_take (rsp_take),
        .bus_gnt (bus_gnt), .bus_req (bus_req),
        .slot_valid (slot_valid), .slot_cmd (slot_cmd), .slot_addr (slot_addr),
        .shr_out (shr_out), .tbl_full (tbl_full)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic quiet();
        loc_valid = 1'b0; loc_cmd = 2'd0; loc_addr = '0;
        snp_valid = 1'b0; snp_cmd = 2'd0; snp_addr = '0; snp_src = '0; snp_tag = '0;
        rsp_valid = 1'b0; rsp_tag = '0; bus_gnt = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        quiet();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic snoop(input logic [1:0] c, input logic [11:0] a,
                         input logic [1:0] s, input logic [2:0] t);
        snp_valid = 1'b1; snp_cmd = c; snp_addr = ADDR_W'(a); snp_src = s; snp_tag = t;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic respond(input logic [2:0] t, input logic e_take, input string req);
        rsp_valid = 1'b1; rsp_tag = t;
        #1 chk(req, rsp_take, e_take);
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    // Offer a local miss; returns in the lookup cycle.
    task automatic offer(input logic [1:0] c, input logic [11:0] a);
        loc_valid = 1'b1; loc_cmd = c; loc_addr = ADDR_W'(a);
        @(negedge clk);
        loc_valid = 1'b0;
    endtask

    task automatic grant_check(input logic [1:0] e_cmd, input string req);
        bus_gnt = 1'b1;
        #1;
        chk(req, slot_valid, 1'b1);
        chk(req, slot_cmd, e_cmd);
        @(negedge clk);
        bus_gnt = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        chk("R1 loc_ready", loc_ready, 1'b1);
        chk("R1 bus_req", bus_req, 1'b0);
        chk("R1 slot_valid", slot_valid, 1'b0);
        chk("R1 shr_out", shr_out, 1'b0);
        chk("R1 tbl_full", tbl_full, 1'b0);
        chk("R1 rsp_take", rsp_take, 1'b0);

        // R2 / R3: table walk
        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].rsp) respond(VECS[i].tag, VECS[i].e_take, "R3 take");
            else snoop(VECS[i].cmd, VECS[i].addr, VECS[i].src, VECS[i].tag);
            chk(VECS[i].rsp ? "R3 full after retire" : "R2 full after snoop",
                tbl_full, VECS[i].e_full);
        end

        // R6 / R7: clean issue, then own snoop and capture (R3)
        do_reset();
        offer(2'd1, 12'h200);
        chk("R6 no req in lookup", bus_req, 1'b0);
        @(negedge clk);
        chk("R6 req after lookup", bus_req, 1'b1);
        grant_check(2'd1, "R7 slot");
        chk("R7 slot_addr", slot_addr, ADDR_W'(12'h200));
        chk("R7 ready after issue", loc_ready, 1'b1);
        snoop(2'd1, 12'h200, 2'd0, 3'd3);
        respond(3'd3, 1'b1, "R3 own take");

        // R4: read joins pending read
        do_reset();
        snoop(2'd1, 12'h300, 2'd1, 3'd4);
        offer(2'd1, 12'h300);
        #1 chk("R4 shared pulse", shr_out, 1'b1);
        @(negedge clk);
        chk("R4 shared one cycle", shr_out, 1'b0);
        chk("R4 ready", loc_ready, 1'b1);
        chk("R4 not issued", bus_req, 1'b0);
        respond(3'd4, 1'b1, "R4 joined take");

        // R5: read held behind exclusive, released on retire (R6 timing)
        do_reset();
        snoop(2'd2, 12'h400, 2'd1, 3'd5);
        offer(2'd1, 12'h400);
        repeat (4) @(negedge clk);
        chk("R5 held no req", bus_req, 1'b0);
        chk("R5 held not ready", loc_ready, 1'b0);
        respond(3'd5, 1'b0, "R5 other take");
        chk("R6 lookup after retire", bus_req, 1'b0);
        @(negedge clk);
        chk("R6 req after retire", bus_req, 1'b1);
        grant_check(2'd1, "R5 released slot");

        // R5: exclusive held behind a pending read
        do_reset();
        snoop(2'd1, 12'h410, 2'd1, 3'd1);
        offer(2'd2, 12'h410);
        repeat (3) @(negedge clk);
        chk("R5 excl held", bus_req, 1'b0);
        chk("R5 excl not ready", loc_ready, 1'b0);

        // R8: conflict during arbitration gives NOP slot
        do_reset();
        offer(2'd1, 12'h500);
        @(negedge clk);
        chk("R8 arbitrating", bus_req, 1'b1);
        snoop(2'd2, 12'h500, 2'd2, 3'd6);
        grant_check(2'd0, "R8 nop slot");
        chk("R8 still held", loc_ready, 1'b0);
        @(negedge clk);
        chk("R8 waits", bus_req, 1'b0);
        respond(3'd6, 1'b0, "R8 other take");
        @(negedge clk);
        chk("R8 rearbitrates", bus_req, 1'b1);

        // R9: upgrade converted to read-exclusive
        do_reset();
        snoop(2'd3, 12'h600, 2'd1, 3'd0);
        offer(2'd3, 12'h600);
        @(negedge clk);
        respond(3'd0, 1'b0, "R9 other take");
        @(negedge clk);
        chk("R9 arbitrating", bus_req, 1'b1);
        grant_check(2'd2, "R9 converted cmd");

        // R10: grant into full table is NOP, no arbitration while full
        do_reset();
        for (int k = 0; k < 7; k++) snoop(2'd1, 12'h800 + 12'(k), 2'd1, 3'(k));
        offer(2'd1, 12'h710);
        @(negedge clk);
        chk("R10 arbitrating", bus_req, 1'b1);
        snoop(2'd1, 12'h7ff, 2'd1, 3'd7);
        chk("R10 full", tbl_full, 1'b1);
        grant_check(2'd0, "R10 nop when full");
        @(negedge clk);
        chk("R10 no req while full", bus_req, 1'b0);
        respond(3'd0, 1'b0, "R10 take");
        @(negedge clk);
        chk("R10 req after space", bus_req, 1'b1);
        grant_check(2'd1, "R10 issue after space");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule